// File: doc/BRIEF.md
# Pipelined Dual-Port Synchronous RAM

This block is a storage array with two independent access ports, A and B. Both ports share one clock. Each port has its own pair of chip enables, a write strobe, an output enable, an address bus, a write-data bus and a read-data bus. Each port can read or write any word in any cycle, at the same time as the other port. Every port captures its enable pair, write strobe, address and write data in an input register on the clock edge. The array operation then runs from those registered values on the following edge and loads the port's read-data register. A read therefore shows at the port two edges after its address is presented.

Each port has two chip enables, one active-low and one active-high. A port is selected only when both are asserted. A cycle sampled with the port deselected does not touch the array, and the port's read-data output drives zero for the following cycle. The output drives again only after the port has taken a selected read cycle. Write cycles also drive zero on that port's read bus. The output enable masks the read bus combinationally.

When both ports write the same word in the same registered cycle, the block raises a one-cycle collision flag. Port A's data is the one kept in the array, so the stored result is always defined.

Top module: `dpr_ram`

## Requirements
- R1: A port that is selected (ce0_n=0, ce1=1) with we=0 at clock edge N shows the word at that address on its read-data bus after edge N+1, while its oe_n is 0.
- R2: A write takes place from the one edge at which the port is selected with we=1. Holding we for more cycles is not needed, and a read of that address registered in a later cycle returns the new data.
- R3: A port sampled with ce0_n=1 or ce1=0 at edge N writes nothing, and its read-data bus is zero after edge N+1.
- R4: After a deselected cycle, a port's read-data bus stays zero until a selected read cycle has been registered, and its data appears one edge after that.
- R5: The two ports read and write different addresses in the same cycle without affecting each other.
- R6: If both ports are selected with we=1 on the same address at edge N, coll is 1 for exactly the cycle after edge N+1, and the word then holds port A's data. In every other case coll is 0.
- R7: A read on one port of an address that the other port writes in the same registered cycle returns the word as it was before that write.
- R8: While a port's oe_n is 1, its read-data bus is zero in the same cycle, whatever the pipeline holds.
- R9: After a write cycle registered at edge N, that port's read-data bus is zero after edge N+1.
- R10: While rst_n is 0, both read-data buses and coll are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_we | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, zero when the output is inactive |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_we | input | 1 | Port B write strobe (1 = write, 0 = read) |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, zero when the output is inactive |
| coll | output | 1 | One-cycle pulse when both ports wrote the same word |

## Verification
The bench checks the two-edge read latency. A design with one pipeline stage too many or too few would return the neighbouring cycle's word. It tests reads that follow a deselect, where a design without the reactivation rule would drive stale data from before the idle period. It creates same-address cycles on the two ports: a write on both must keep port A's data and flag coll, and a write on one port with a read on the other must return the old word. A design that let port B win, or that read after writing, gives different data in those cycles. Random traffic over a small hot address region covers these cases again with output enables toggling, so that any gating that leaks or holds data shows up as a data mismatch.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  // Port indices inside the shared array; the lower index has write priority
  localparam int unsigned NPORTS = 2;
  typedef enum logic {PORT_A = 1'b0, PORT_B = 1'b1} port_id_e;
endpackage

// File: rtl/dpr_in_stage.sv
// Input register stage of one port: enables, strobe, address, write data
module dpr_in_stage #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          sel_q,
  output logic          we_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  logic          sel_d;
  logic          we_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;
  logic          addr_en;
  logic          data_en;

  always_comb begin
    sel_d   = ~ce0_n & ce1;
    we_d    = sel_d & we;
    // Address and data registers only load in selected cycles
    addr_en = sel_d;
    data_en = sel_d & we;
    addr_d  = addr_en ? addr  : addr_q;
    wdata_d = data_en ? wdata : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      sel_q   <= sel_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end
endmodule

// File: rtl/dpr_array.sv
// Shared storage: read-before-write, lowest port index wins on a write clash
module dpr_array #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36,
  parameter int unsigned NP = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         wr_en,
  input  logic [NP-1:0][AW-1:0] addr,
  input  logic [NP-1:0][DW-1:0] wdata,
  output logic [NP-1:0][DW-1:0] rd_data,
  output logic                  coll
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          coll_d;
  logic          coll_q;

  // Combinational read of the current contents; writes land at the edge
  generate
    for (genvar p = 0; p < NP; p++) begin : g_rd
      assign rd_data[p] = mem[addr[p]];
    end
  endgenerate

  // Later assignment wins: walk from the highest port down to port 0
  always_ff @(posedge clk) begin
    for (int p = NP - 1; p >= 0; p--) begin
      if (wr_en[p]) mem[addr[p]] <= wdata[p];
    end
  end

  always_comb begin
    coll_d = 1'b0;
    for (int i = 0; i < NP; i++) begin
      for (int j = i + 1; j < NP; j++) begin
        if (wr_en[i] && wr_en[j] && (addr[i] == addr[j])) coll_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coll_q <= 1'b0;
    else        coll_q <= coll_d;
  end

  assign coll = coll_q;
endmodule

// File: rtl/dpr_out_stage.sv
// Output register of one port with reactivation and output-enable gating
module dpr_out_stage #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_q,
  input  logic          we_q,
  input  logic [DW-1:0] rd_data,
  input  logic          oe_n,
  output logic [DW-1:0] rdata
);
  logic          act_d;
  logic          act_q;
  logic [DW-1:0] data_d;
  logic [DW-1:0] data_q;

  always_comb begin
    // Drive only after a registered, selected read cycle
    act_d  = sel_q & ~we_q;
    data_d = act_d ? rd_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      data_q <= '0;
    end else begin
      act_q  <= act_d;
      data_q <= data_d;
    end
  end

  assign rdata = (act_q && !oe_n) ? data_q : '0;
endmodule

// File: rtl/dpr_ram.sv
module dpr_ram
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_ce0_n,
  input  logic          a_ce1,
  input  logic          a_we,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_ce0_n,
  input  logic          b_ce1,
  input  logic          b_we,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          coll
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // Gather both ports into indexed buses
  logic [NPORTS-1:0]         p_ce0_n, p_ce1, p_we, p_oe_n;
  logic [NPORTS-1:0][AW-1:0] p_addr;
  logic [NPORTS-1:0][DW-1:0] p_wdata;
  logic [NPORTS-1:0][DW-1:0] p_rdata;

  logic [NPORTS-1:0]         sel_q, we_q, wr_en;
  logic [NPORTS-1:0][AW-1:0] addr_q;
  logic [NPORTS-1:0][DW-1:0] wdata_q;
  logic [NPORTS-1:0][DW-1:0] rd_data;

  assign p_ce0_n = {b_ce0_n, a_ce0_n};
  assign p_ce1   = {b_ce1,   a_ce1};
  assign p_we    = {b_we,    a_we};
  assign p_oe_n  = {b_oe_n,  a_oe_n};
  assign p_addr  = {b_addr,  a_addr};
  assign p_wdata = {b_wdata, a_wdata};

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      dpr_in_stage #(.AW(AW), .DW(DW)) u_in (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .ce0_n   (p_ce0_n[p]),
        .ce1     (p_ce1[p]),
        .we      (p_we[p]),
        .addr    (p_addr[p]),
        .wdata   (p_wdata[p]),
        .sel_q   (sel_q[p]),
        .we_q    (we_q[p]),
        .addr_q  (addr_q[p]),
        .wdata_q (wdata_q[p])
      );

      assign wr_en[p] = sel_q[p] & we_q[p];

      dpr_out_stage #(.DW(DW)) u_out (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .sel_q   (sel_q[p]),
        .we_q    (we_q[p]),
        .rd_data (rd_data[p]),
        .oe_n    (p_oe_n[p]),
        .rdata   (p_rdata[p])
      );
    end
  endgenerate

  dpr_array #(.AW(AW), .DW(DW), .NP(NPORTS)) u_array (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .rd_data (rd_data),
    .coll    (coll)
  );

  assign a_rdata = p_rdata[PORT_A];
  assign b_rdata = p_rdata[PORT_B];
endmodule

// File: rtl/dpr_ram_chk.sv
module dpr_ram_chk #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_ce0_n,
  input logic          a_ce1,
  input logic          a_we,
  input logic          a_oe_n,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          b_ce0_n,
  input logic          b_ce1,
  input logic          b_we,
  input logic          b_oe_n,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          coll
);
  logic a_sel, b_sel, a_wr, b_wr, same_wr;
  assign a_sel   = !a_ce0_n && a_ce1;
  assign b_sel   = !b_ce0_n && b_ce1;
  assign a_wr    = a_sel && a_we;
  assign b_wr    = b_sel && b_we;
  assign same_wr = a_wr && b_wr && (a_addr == b_addr);

  // R6
  coll_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll == $past(same_wr, 2));

  // R3
  a_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(a_sel, 2) |-> a_rdata == '0);

  // R3
  b_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(b_sel, 2) |-> b_rdata == '0);

  // R9
  a_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(a_wr, 2) |-> a_rdata == '0);

  // R9
  b_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(b_wr, 2) |-> b_rdata == '0);

  // R8
  oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe_n |-> a_rdata == '0) and (b_oe_n |-> b_rdata == '0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (a_rdata == '0 && b_rdata == '0 && !coll));
endmodule

bind dpr_ram dpr_ram_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_dpr_ram.sv
`timescale 1ns/1ps
module tb_dpr_ram;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 36;
  localparam int unsigned DEPTH = 1 << AW;

  typedef struct packed {
    logic          ce0_n;
    logic          ce1;
    logic          we;
    logic          oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } op_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_ce0_n, a_ce1, a_we, a_oe_n, b_ce0_n, b_ce1, b_we, b_oe_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic          coll;

  always #2.5 clk = ~clk;

  dpr_ram #(.AW(AW), .DW(DW)) dut (.*);

  int vectors = 0;
  int fails   = 0;
  string phase_tag = "";

  logic [DW-1:0] ref_mem [DEPTH];
  op_t           pend_a, pend_b;
  logic          exp_act_a, exp_act_b, exp_coll;
  logic [DW-1:0] exp_dat_a, exp_dat_b;
  logic          pend_a_desel, pend_b_desel, pend_a_wr, pend_b_wr;

  function automatic logic sel_of(op_t o);
    return !o.ce0_n && o.ce1;
  endfunction

  function automatic logic [DW-1:0] gate(logic act, logic oe_n, logic [DW-1:0] d);
    return (act && !oe_n) ? d : '0;
  endfunction

  function automatic op_t mk(logic sel, logic we, logic [AW-1:0] ad, logic [DW-1:0] wd);
    op_t o;
    o.ce0_n = !sel; o.ce1 = 1'b1; o.we = we; o.oe_n = 1'b0;
    o.addr = ad; o.wdata = wd;
    return o;
  endfunction

  function automatic op_t idle_op();
    return mk(1'b0, 1'b0, '0, '0);
  endfunction

  function automatic logic [DW-1:0] rnd_data();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic drive(op_t a, op_t b);
    a_ce0_n = a.ce0_n; a_ce1 = a.ce1; a_we = a.we; a_oe_n = a.oe_n;
    a_addr = a.addr; a_wdata = a.wdata;
    b_ce0_n = b.ce0_n; b_ce1 = b.ce1; b_we = b.we; b_oe_n = b.oe_n;
    b_addr = b.addr; b_wdata = b.wdata;
  endtask

  // Model of the operation registered one edge earlier, run at this edge
  task automatic model_exec();
    logic sa, sb;
    sa = sel_of(pend_a); sb = sel_of(pend_b);
    pend_a_desel = !sa; pend_b_desel = !sb;
    pend_a_wr = sa && pend_a.we; pend_b_wr = sb && pend_b.we;
    exp_act_a = sa && !pend_a.we;
    exp_act_b = sb && !pend_b.we;
    if (exp_act_a) exp_dat_a = ref_mem[pend_a.addr];
    if (exp_act_b) exp_dat_b = ref_mem[pend_b.addr];
    exp_coll = pend_a_wr && pend_b_wr && (pend_a.addr == pend_b.addr);
    if (pend_b_wr) ref_mem[pend_b.addr] = pend_b.wdata;
    if (pend_a_wr) ref_mem[pend_a.addr] = pend_a.wdata;
  endtask

  function automatic string port_tag(logic oe_n, logic desel, logic wr);
    if (phase_tag != "") return phase_tag;
    if (oe_n)  return "R8";
    if (desel) return "R3";
    if (wr)    return "R9";
    return "R1";
  endfunction

  task automatic check_val(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(op_t a, op_t b);
    drive(a, b);
    @(posedge clk);
    model_exec();
    pend_a = a; pend_b = b;
    @(negedge clk);
    check_val(port_tag(a.oe_n, pend_a_desel, pend_a_wr), "port A rdata", a_rdata,
              gate(exp_act_a, a.oe_n, exp_dat_a));
    check_val(port_tag(b.oe_n, pend_b_desel, pend_b_wr), "port B rdata", b_rdata,
              gate(exp_act_b, b.oe_n, exp_dat_b));
    check_val((phase_tag != "") ? phase_tag : "R6", "coll", DW'(coll), DW'(exp_coll));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    op_t a, b;
    logic [DW-1:0] d0, d1;
    void'($urandom(32'h5eed_0d11));
    rst_n = 1'b0;
    drive(idle_op(), idle_op());
    pend_a = idle_op(); pend_b = idle_op();
    exp_act_a = 0; exp_act_b = 0; exp_coll = 0; exp_dat_a = '0; exp_dat_b = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check_val("R10", "port A rdata in reset", a_rdata, '0);
    check_val("R10", "port B rdata in reset", b_rdata, '0);
    check_val("R10", "coll in reset", DW'(coll), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Fill the array: A takes even words, B odd words (R5)
    phase_tag = "R5";
    for (int i = 0; i < DEPTH / 2; i++)
      cycle(mk(1, 1, AW'(2 * i), rnd_data()), mk(1, 1, AW'(2 * i + 1), rnd_data()));

    // R1 and R5: crossed simultaneous reads
    phase_tag = "R1";
    cycle(mk(1, 0, 10'd4, '0), mk(1, 0, 10'd7, '0));
    cycle(mk(1, 0, 10'd7, '0), mk(1, 0, 10'd4, '0));
    cycle(idle_op(), idle_op());

    // R2: write strobe held for a single edge, then read back
    phase_tag = "R2";
    cycle(mk(1, 1, 10'd20, 36'h0_1234_5678), idle_op());
    cycle(mk(1, 0, 10'd20, 36'hF_FFFF_FFFF), idle_op());
    cycle(idle_op(), idle_op());

    // R3: deselected write via ce1 low must not land
    phase_tag = "R3";
    a = mk(1, 1, 10'd20, 36'hA_AAAA_AAAA); a.ce1 = 1'b0;
    cycle(a, idle_op());
    cycle(mk(1, 0, 10'd20, '0), idle_op());
    cycle(idle_op(), idle_op());

    // R4: read, deselect, then reactivate
    phase_tag = "R4";
    cycle(idle_op(), mk(1, 0, 10'd20, '0));
    cycle(idle_op(), idle_op());
    cycle(idle_op(), idle_op());
    cycle(idle_op(), mk(1, 0, 10'd21, '0));
    cycle(idle_op(), idle_op());

    // R7: B reads the word A writes in the same cycle, gets the old value
    phase_tag = "R7";
    d0 = 36'h5_0505_0505;
    cycle(mk(1, 1, 10'd30, d0), mk(1, 0, 10'd30, '0));
    cycle(idle_op(), mk(1, 0, 10'd30, '0));
    cycle(idle_op(), idle_op());

    // R6: same-address writes, port A must win
    phase_tag = "R6";
    d0 = 36'h1_1111_1111; d1 = 36'h2_2222_2222;
    cycle(mk(1, 1, 10'd40, d0), mk(1, 1, 10'd40, d1));
    cycle(mk(1, 0, 10'd40, '0), mk(1, 0, 10'd40, '0));
    cycle(idle_op(), idle_op());
    check_val("R6", "port B word after clash", b_rdata, d0);

    // R8: output enable masks valid data
    phase_tag = "R8";
    cycle(mk(1, 0, 10'd40, '0), idle_op());
    a = idle_op(); a.oe_n = 1'b1;
    cycle(a, idle_op());

    // Random traffic over a small hot region
    phase_tag = "";
    for (int n = 0; n < 4000; n++) begin
      a = mk(($urandom() % 5) != 0, $urandom() % 2, AW'($urandom() % 16), rnd_data());
      b = mk(($urandom() % 5) != 0, $urandom() % 2, AW'($urandom() % 16), rnd_data());
      if ($urandom() % 3 == 0) begin a.ce0_n = 1'b0; a.ce1 = 1'b0; end
      a.oe_n = ($urandom() % 6) == 0;
      b.oe_n = ($urandom() % 6) == 0;
      cycle(a, b);
    end
    cycle(idle_op(), idle_op());
    cycle(idle_op(), idle_op());

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule